// File: doc/BRIEF.md
# Windowed Independent Watchdog Timer

This block is a count-down watchdog clocked by its own slow clock through a selectable prescaler. Software must kick it with a two-write sequence while the remaining count lies inside a window. The window's upper and lower edges are each chosen as a quarter step of the period. A kick outside the window, or a count that runs past zero, sets a sticky error flag and reloads the counter. It also fires a one-cycle pulse on either a reset-request or a non-maskable-interrupt output.

All settings come from a 12-bit option word. The block captures this word once, on the first clock edge after reset is released, and holds it until the next reset. A small register interface gives the kick register, a status register with write-one-to-clear flags, and a read of the live counter. Writes are taken on the clock edge. Reads are combinational on the read address.

Top module: `iwin_wdt`

## Requirements
- R1: The option word is captured on the first rising edge after reset release and ignored afterwards. Its bit layout is: bit 0 auto-start, bits 2:1 timeout code, bits 5:3 divider code, bits 7:6 window-start code, bits 9:8 window-end code, bit 10 response select, bit 11 low-power stop.
- R2: Timeout code 0/1/2/3 selects a period P of 128/512/1024/2048 ticks. Each reload sets the counter to P-1, and each prescaled tick decrements it.
- R3: Divider code 0..5 gives one tick every 1/16/32/64/128/256 clocks, and codes 6 and 7 act as 256. The prescaler restarts on every reload, so the first decrement comes that many clocks after the reload edge.
- R4: A kick is a write of 0x00 followed by a write of 0xFF to address 0. A write of any other value to address 0 cancels a pending 0x00, and a 0xFF without a pending 0x00 does nothing.
- R5: A kick is inside the window when the count C meets C < P*(s+1)/4 and C >= P*(3-e)/4. Here s is the window-start code and e is the window-end code. Codes s=3 and e=3 each remove that bound.
- R6: A kick outside the window sets the refresh-error flag (status bit 1) and reloads the counter. A kick inside the window reloads it without an error.
- R7: A decrement attempted at count 0 is an underflow. It sets the underflow flag (status bit 0), reloads to P-1, and counting goes on.
- R8: Each error drives a pulse exactly one clock long, one cycle after the edge that detected it. The pulse goes on nmi_req when the response select is 1 and on rst_req when it is 0. Both outputs are low after reset.
- R9: Reading address 1 returns {refresh-error, underflow} in bits 1:0. Writing address 1 clears each flag whose data bit is 1. A flag that is set on the same edge stays set.
- R10: Reading address 2 returns the current count, zero-extended.
- R11: With auto-start at 1 the counter runs from the capture edge. With auto-start at 0 it holds at P-1 until the first kick, which starts it without a window check.
- R12: With low-power stop at 1 and lp_mode high, the counter and prescaler hold. With low-power stop at 0, lp_mode has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Dedicated watchdog clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| opt_word | input | 12 | Static option word, captured after reset |
| lp_mode | input | 1 | Low-power mode indication |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Write address (0 kick, 1 status) |
| wr_data | input | DATA_W | Write data |
| rd_addr | input | 2 | Read address (1 status, 2 counter) |
| rd_data | output | DATA_W | Read data |
| rst_req | output | 1 | One-cycle reset request pulse |
| nmi_req | output | 1 | One-cycle non-maskable interrupt pulse |

## Verification
The bench builds the block with its default parameters, a 16-bit data path. It reaches the different behaviours by resetting with a new option word each time. Periods of 128 and 512 with dividers of 1 and 16 keep exact underflow and first-decrement timing inside a short run, and they cover both start modes, both response outputs and both low-power settings. Random window codes and random kick instants, each checked against a bench-side window function, test the window compare on both sides of each edge.

// File: rtl/iwin_wdt_pkg.sv
package iwin_wdt_pkg;

  localparam int MAX_TIMEOUT = 2048;
  localparam int CNT_W       = $clog2(MAX_TIMEOUT);
  localparam int PER_W       = CNT_W + 1;
  localparam int MAX_DIV     = 256;
  localparam int PRE_W       = $clog2(MAX_DIV);
  localparam int DIV_W       = PRE_W + 1;
  localparam int OPT_W       = 12;
  localparam int THR_W       = PER_W + 3;

  localparam logic [7:0] KICK_ARM  = 8'h00;
  localparam logic [7:0] KICK_FIRE = 8'hFF;

  typedef struct packed {
    logic       lp_stop;
    logic       nmi_sel;
    logic [1:0] win_end;
    logic [1:0] win_start;
    logic [2:0] div_sel;
    logic [1:0] to_sel;
    logic       auto_start;
  } opt_t;

  typedef enum logic [1:0] {
    ADDR_KICK  = 2'd0,
    ADDR_STAT  = 2'd1,
    ADDR_COUNT = 2'd2,
    ADDR_SPARE = 2'd3
  } addr_e;

  function automatic logic [PER_W-1:0] period_of(input logic [1:0] sel);
    logic [PER_W-1:0] p;
    case (sel)
      2'd0:    p = PER_W'(128);
      2'd1:    p = PER_W'(512);
      2'd2:    p = PER_W'(1024);
      default: p = PER_W'(2048);
    endcase
    return p;
  endfunction

  function automatic logic [DIV_W-1:0] div_of(input logic [2:0] sel);
    logic [DIV_W-1:0] d;
    if (sel == 3'd0)
      d = DIV_W'(1);
    else if (sel > 3'd5)
      d = DIV_W'(MAX_DIV);
    else
      d = DIV_W'(8) << sel;
    return d;
  endfunction

endpackage

// File: rtl/iwin_wdt_prescaler.sv
module iwin_wdt_prescaler
  import iwin_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cnt_en,
  input  logic       clr,
  input  logic [2:0] div_sel,
  output logic       tick
);

  logic [PRE_W-1:0] pre_q;
  logic [PRE_W-1:0] pre_d;
  logic [DIV_W-1:0] lim;
  logic             last;

  always_comb begin
    lim  = div_of(div_sel);
    last = (DIV_W'(pre_q) == (lim - DIV_W'(1)));
    tick = cnt_en && last;
    pre_d = pre_q;
    if (clr)
      pre_d = '0;
    else if (cnt_en)
      pre_d = last ? '0 : pre_q + PRE_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      pre_q <= '0;
    else
      pre_q <= pre_d;
  end

  AST_PRESCALE_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    DIV_W'(pre_q) < lim); // R3

endmodule

// File: rtl/iwin_wdt_kickseq.sv
module iwin_wdt_kickseq
  import iwin_wdt_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       kick_wr,
  input  logic [7:0] kick_byte,
  output logic       fire
);

  logic armed_q;
  logic armed_d;

  always_comb begin
    fire    = kick_wr && armed_q && (kick_byte == KICK_FIRE);
    armed_d = armed_q;
    if (kick_wr)
      armed_d = (kick_byte == KICK_ARM);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      armed_q <= 1'b0;
    else
      armed_q <= armed_d;
  end

  AST_FIRE_CLEARS_ARM: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> !armed_q); // R4

endmodule

// File: rtl/iwin_wdt_window.sv
module iwin_wdt_window
  import iwin_wdt_pkg::*;
(
  input  logic [PER_W-1:0] period,
  input  logic [1:0]       win_start,
  input  logic [1:0]       win_end,
  input  logic [CNT_W-1:0] cnt,
  output logic             in_win
);

  logic [THR_W-1:0] s_mul;
  logic [THR_W-1:0] e_mul;
  logic [THR_W-1:0] s_thr;
  logic [THR_W-1:0] e_thr;

  always_comb begin
    s_mul  = THR_W'(period) * (THR_W'(win_start) + THR_W'(1));
    e_mul  = THR_W'(period) * (THR_W'(3) - THR_W'(win_end));
    s_thr  = s_mul >> 2;
    e_thr  = e_mul >> 2;
    in_win = (THR_W'(cnt) < s_thr) && (THR_W'(cnt) >= e_thr);
  end

endmodule

// File: rtl/iwin_wdt.sv
module iwin_wdt
  import iwin_wdt_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPT_W-1:0]  opt_word,
  input  logic              lp_mode,
  input  logic              wr_en,
  input  logic [1:0]        wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [1:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rst_req,
  output logic              nmi_req
);

  opt_t             opt_q, opt_d;
  logic             loaded_q;
  logic             run_q, run_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             uf_q, uf_d;
  logic             rf_q, rf_d;
  logic             rst_req_q, rst_req_d;
  logic             nmi_req_q, nmi_req_d;

  logic [PER_W-1:0] period;
  logic [CNT_W-1:0] reload_val;
  logic             kick_wr;
  logic             fire;
  logic             stop;
  logic             tick;
  logic             reload;
  logic             in_win;
  logic             uf_set, rf_set;
  logic             stat_wr;

  assign period     = period_of(opt_q.to_sel);
  assign reload_val = CNT_W'(period - PER_W'(1));
  assign kick_wr    = loaded_q && wr_en && (wr_addr == ADDR_KICK);
  assign stat_wr    = loaded_q && wr_en && (wr_addr == ADDR_STAT);
  assign stop       = opt_q.lp_stop && lp_mode;

  iwin_wdt_kickseq u_kick (
    .clk       (clk),
    .rst_n     (rst_n),
    .kick_wr   (kick_wr),
    .kick_byte (wr_data[7:0]),
    .fire      (fire)
  );

  iwin_wdt_prescaler u_pre (
    .clk     (clk),
    .rst_n   (rst_n),
    .cnt_en  (loaded_q && run_q && !stop),
    .clr     (reload),
    .div_sel (opt_q.div_sel),
    .tick    (tick)
  );

  iwin_wdt_window u_win (
    .period    (period),
    .win_start (opt_q.win_start),
    .win_end   (opt_q.win_end),
    .cnt       (cnt_q),
    .in_win    (in_win)
  );

  always_comb begin
    opt_d  = opt_q;
    run_d  = run_q;
    cnt_d  = cnt_q;
    uf_set = 1'b0;
    rf_set = 1'b0;
    reload = 1'b0;
    if (!loaded_q) begin
      opt_d = opt_t'(opt_word);
      run_d = opt_word[0];
      cnt_d = CNT_W'(period_of(opt_word[2:1]) - PER_W'(1));
    end else if (fire) begin
      reload = 1'b1;
      cnt_d  = reload_val;
      if (!run_q)
        run_d = 1'b1;
      else if (!in_win)
        rf_set = 1'b1;
    end else if (tick) begin
      if (cnt_q == '0) begin
        reload = 1'b1;
        uf_set = 1'b1;
        cnt_d  = reload_val;
      end else begin
        cnt_d = cnt_q - CNT_W'(1);
      end
    end
    uf_d = uf_set | (uf_q & ~(stat_wr & wr_data[0]));
    rf_d = rf_set | (rf_q & ~(stat_wr & wr_data[1]));
    rst_req_d = (uf_set | rf_set) & ~opt_q.nmi_sel;
    nmi_req_d = (uf_set | rf_set) &  opt_q.nmi_sel;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      opt_q     <= '0;
      loaded_q  <= 1'b0;
      run_q     <= 1'b0;
      cnt_q     <= '0;
      uf_q      <= 1'b0;
      rf_q      <= 1'b0;
      rst_req_q <= 1'b0;
      nmi_req_q <= 1'b0;
    end else begin
      opt_q     <= opt_d;
      loaded_q  <= 1'b1;
      run_q     <= run_d;
      cnt_q     <= cnt_d;
      uf_q      <= uf_d;
      rf_q      <= rf_d;
      rst_req_q <= rst_req_d;
      nmi_req_q <= nmi_req_d;
    end
  end

  always_comb begin
    case (rd_addr)
      ADDR_STAT:  rd_data = DATA_W'({rf_q, uf_q});
      ADDR_COUNT: rd_data = DATA_W'(cnt_q);
      default:    rd_data = '0;
    endcase
  end

  assign rst_req = rst_req_q;
  assign nmi_req = nmi_req_q;

  AST_OPT_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |=> $stable(opt_q)); // R1
  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    loaded_q |-> (PER_W'(cnt_q) < period)); // R2
  AST_PULSE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_q || nmi_req_q) |=> !(rst_req_q || nmi_req_q)); // R8
  AST_PULSE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({rst_req_q, nmi_req_q})); // R8
  AST_PULSE_FLAGGED: assert property (@(posedge clk) disable iff (!rst_n)
    (rst_req_q || nmi_req_q) |-> (uf_q || rf_q)); // R9
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && !run_q && !fire) |=> ($stable(cnt_q) && !run_q)); // R11
  AST_LP_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded_q && stop && !fire) |=> $stable(cnt_q)); // R12

endmodule

// File: tb/iwin_wdt_test.sv
module iwin_wdt_test;

  localparam int CLK_PERIOD = 10;
  localparam int DW = 16;

  logic          clk;
  logic          rst_n;
  logic [11:0]   opt_word;
  logic          lp_mode;
  logic          wr_en;
  logic [1:0]    wr_addr;
  logic [DW-1:0] wr_data;
  logic [1:0]    rd_addr;
  logic [DW-1:0] rd_data;
  logic          rst_req;
  logic          nmi_req;

  int n_chk = 0;
  int n_err = 0;
  bit done  = 0;

  iwin_wdt #(.DATA_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .opt_word(opt_word), .lp_mode(lp_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data),
    .rst_req(rst_req), .nmi_req(nmi_req)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [11:0] mk_opt(input bit auto_s, input int to, input int dv,
                                         input int ws, input int we, input bit nmi, input bit lps);
    return {lps, nmi, 2'(we), 2'(ws), 3'(dv), 2'(to), auto_s};
  endfunction

  function automatic bit win_ok(input int c, input int p, input int s, input int e);
    int hi = p * (s + 1) / 4;
    int lo = p * (3 - e) / 4;
    return (c < hi) && (c >= lo);
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_err++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycle();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [DW-1:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    cycle();
    wr_en = 1'b0; wr_data = '0;
  endtask

  task automatic rd(input logic [1:0] a, output int v);
    rd_addr = a;
    #1;
    v = int'(rd_data);
  endtask

  task automatic do_reset(input logic [11:0] o);
    rst_n = 1'b0; opt_word = o; lp_mode = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    repeat (2) @(negedge clk);
    rst_n = 1'b1;
    cycle();
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=%0d expected=%0d", 0, 1);
      finish_run();
    end
  end

  initial begin
    int v;
    void'($urandom(32'h5EED_1234));

    // Auto-start, P=128, div 1, no window, reset response
    rst_n = 1'b0; opt_word = '0; lp_mode = 1'b0;
    wr_en = 1'b0; wr_addr = '0; wr_data = '0; rd_addr = '0;
    #2;
    chk("R8 reset rst_req low", int'(rst_req), 0);
    chk("R8 reset nmi_req low", int'(nmi_req), 0);
    do_reset(mk_opt(1, 0, 0, 3, 3, 0, 0));
    opt_word = '1; // R1: later changes must be ignored
    rd(2'd2, v); chk("R10 R11 count after capture", v, 127);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h00FF);
    rd(2'd2, v); chk("R4 kick reloads", v, 127);
    rd(2'd1, v); chk("R5 unbounded window no error", v, 0);
    repeat (127) cycle();
    rd(2'd2, v); chk("R2 R1 count reaches zero", v, 0);
    cycle();
    rd(2'd1, v); chk("R7 underflow flag", v, 1);
    chk("R8 rst_req pulse", int'(rst_req), 1);
    chk("R8 nmi_req quiet", int'(nmi_req), 0);
    rd(2'd2, v); chk("R7 reload after underflow", v, 127);
    cycle();
    chk("R8 pulse one cycle", int'(rst_req), 0);
    wr(2'd1, 16'h0001);
    rd(2'd1, v); chk("R9 clear underflow", v, 0);
    repeat (10) cycle();
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h005A);
    wr(2'd0, 16'h00FF);
    rd(2'd2, v); chk("R4 cancelled sequence no reload", int'(v < 127), 1);
    rd(2'd1, v); chk("R4 cancelled sequence no error", v, 0);

    // Window [32,64), NMI response
    do_reset(mk_opt(1, 0, 0, 1, 2, 1, 0));
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h00FF);
    rd(2'd1, v); chk("R6 early kick error", v, 2);
    chk("R8 nmi pulse", int'(nmi_req), 1);
    chk("R8 rst quiet", int'(rst_req), 0);
    rd(2'd2, v); chk("R6 reload on refresh error", v, 127);
    wr(2'd1, 16'h0002);
    repeat (68) cycle();
    wr(2'd0, 16'h0000);
    rd(2'd2, v); chk("R5 count inside window", v, 57);
    wr(2'd0, 16'h00FF);
    rd(2'd1, v); chk("R5 kick inside window", v, 0);
    repeat (100) cycle();
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h00FF);
    rd(2'd1, v); chk("R5 late kick error", v, 2);

    // Register start, P=512, div 16
    do_reset(mk_opt(0, 1, 1, 3, 3, 0, 0));
    repeat (50) cycle();
    rd(2'd2, v); chk("R11 idle until kick", v, 511);
    wr(2'd0, 16'h0000);
    wr(2'd0, 16'h00FF);
    rd(2'd1, v); chk("R11 first kick no error", v, 0);
    repeat (15) cycle();
    rd(2'd2, v); chk("R3 no decrement before 16 clocks", v, 511);
    cycle();
    rd(2'd2, v); chk("R3 decrement at 16 clocks", v, 510);

    // Low-power stop enabled
    do_reset(mk_opt(1, 0, 0, 3, 3, 0, 1));
    lp_mode = 1'b1;
    repeat (30) cycle();
    rd(2'd2, v); chk("R12 frozen in low power", v, 127);
    lp_mode = 1'b0;
    repeat (5) cycle();
    rd(2'd2, v); chk("R12 resumes after low power", v, 122);

    // Low-power stop disabled
    do_reset(mk_opt(1, 0, 0, 3, 3, 0, 0));
    lp_mode = 1'b1;
    repeat (30) cycle();
    rd(2'd2, v); chk("R12 lp_mode ignored", v, 97);
    lp_mode = 1'b0;

    // Random window codes and kick instants
    for (int cfg = 0; cfg < 6; cfg++) begin
      int ws = int'($urandom % 4);
      int we = int'($urandom % 4);
      bit nm = bit'($urandom % 2);
      do_reset(mk_opt(1, 0, 0, ws, we, nm, 0));
      for (int it = 0; it < 25; it++) begin
        int c, c2, r, st;
        bit ok;
        rd(2'd2, c);
        r = (c > 3) ? int'($urandom % (c - 2)) : 0;
        repeat (r) cycle();
        wr(2'd0, 16'h0000);
        rd(2'd2, c2);
        ok = win_ok(c2, 128, ws, we);
        wr(2'd0, 16'h00FF);
        rd(2'd2, v); chk("R6 random reload", v, 127);
        rd(2'd1, st); chk("R5 random window flag", st, ok ? 0 : 2);
        chk("R8 random nmi pulse", int'(nmi_req), (!ok && nm) ? 1 : 0);
        chk("R8 random rst pulse", int'(rst_req), (!ok && !nm) ? 1 : 0);
        if (!ok) wr(2'd1, 16'h0002);
      end
    end

    done = 1;
    finish_run();
  end

endmodule